// File: doc/BRIEF.md
# Control Stream Channel Assembler

This block builds a bit-serial control stream of 32 eight-bit channels for each system frame. It gathers several inputs and places each one in a fixed channel:

- signalling bytes received in timeslot 16 over a 16-frame multiframe;
- the two alternating timeslot-0 alignment words and their spare international bits;
- externally supplied status bits;
- a 9-bit phase measurement;
- a local count of CRC error events.

A downstream controller reads the stream to learn the state of the line interface without a separate register path.

The assembler latches the whole 32-byte picture on the system frame pulse. Each channel then holds one stable value for the entire frame, even while the capture registers keep updating. The stream goes out most significant bit first, one bit per clock, beginning the cycle after the frame pulse. With no new pulse, the sequencer wraps and repeats the same frame. The CRC error count wraps modulo 256. When the maintenance input is high, a one-second tick clears the count. The error bit of the first status word toggles after every block of errored alignment events.

Top module: `ctl_stream_asm`

## Requirements
- R1: A synchronous reset forces `ctl_so_o` to 1 from the next cycle. Until the first frame pulse, every bit output is 1. The first frame after reset shows channels 0 to 17 as 0xFF, a CRC count of 0 and an error bit of 0.
- R2: On the clock edge where `fp_i` is 1, bit 7 of channel 0 appears on `ctl_so_o`. Each following cycle outputs the next bit, MSB first, channel 0 up to channel 31 (256 cycles). If no new pulse arrives, the same 256 bits repeat.
- R3: Channel 0 carries the last signalling byte captured for multiframe position 0. Channel n (1 to 15) carries the last byte captured for position n.
- R4: Channel 16 carries the last alignment byte captured with an even frame number. Channel 17 carries the last one captured with an odd frame number.
- R5: Channel 18 is {`stat_i`[6:0], err}, with err in bit 0. err starts at 0 and inverts on every 16th `fae_i` event.
- R6: Channel 19 carries `phase_i`[7:0]. Bit 0 of channel 21 carries `phase_i`[8].
- R7: Channel 21 bits 7 down to 1 hold: bit 7 of the alignment byte last captured for frame 13, bit 7 of the one for frame 15, `crc_rfr_i`, `crc_sync_i`, then three ones.
- R8: Channel 20 counts `crc_err_i` cycles and wraps from 255 to 0.
- R9: A cycle with `maint_i` and `sec_tick_i` both high sets the count to 0, or to 1 if `crc_err_i` is also high. A tick while `maint_i` is low has no effect.
- R10: Channels 22 to 31 are always 0xFF.
- R11: All channel contents are sampled at the frame pulse. A capture made during a frame shows up only from the next frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one stream bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | System frame pulse, one cycle |
| sig_vld_i | input | 1 | Signalling byte capture strobe |
| sig_frm_i | input | 4 | Multiframe position of the signalling byte |
| sig_byte_i | input | 8 | Timeslot-16 byte |
| aln_vld_i | input | 1 | Alignment byte capture strobe |
| aln_frm_i | input | 4 | Frame number of the alignment byte |
| aln_byte_i | input | 8 | Timeslot-0 byte |
| stat_i | input | 7 | Status bits for channel 18 |
| fae_i | input | 1 | Errored alignment byte event |
| phase_i | input | 9 | Phase measurement word |
| crc_sync_i | input | 1 | CRC multiframe sync status |
| crc_rfr_i | input | 1 | CRC reframe status |
| crc_err_i | input | 1 | CRC error event |
| maint_i | input | 1 | Enables the per-second count clear |
| sec_tick_i | input | 1 | One-second tick |
| ctl_so_o | output | 1 | Serial control stream |

## Verification
The bench sweeps four patterns over all sixteen signalling positions and all sixteen alignment frames. Each pattern gives every channel a different byte, so an off-by-one channel or a swapped even/odd word shows up as a mismatch. Across the patterns, the phase word runs through zero, all ones and the two alternating-bit values, and the status flags cover all four combinations. This separates the ninth phase bit from the low byte and catches bit-order mistakes in the channel 21 layout. Event sequences check the count at the exact wrap, the clear with and without a coincident error, and the error bit one event either side of its toggle point. A write during a frame separates frame-pulse latching from live pass-through.

// File: rtl/ctl_stream_pkg.sv
package ctl_stream_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CH_FAS  = 16;
  localparam int unsigned CH_NFAS = 17;
  localparam int unsigned CH_MSW  = 18;
  localparam int unsigned CH_PHS  = 19;
  localparam int unsigned CH_CRC  = 20;
  localparam int unsigned CH_MSW2 = 21;
  typedef logic [BYTE_W-1:0] chan_t;
endpackage

// File: rtl/csa_capture.sv
module csa_capture
  import ctl_stream_pkg::*;
#(
  parameter int unsigned MF_LEN = 16,
  parameter int unsigned SI_A   = 13,
  parameter int unsigned SI_B   = 15,
  parameter int unsigned FW     = $clog2(MF_LEN)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sig_vld,
  input  logic [FW-1:0]                sig_frm,
  input  chan_t                        sig_byte,
  input  logic                         aln_vld,
  input  logic [FW-1:0]                aln_frm,
  input  chan_t                        aln_byte,
  output logic [MF_LEN-1:0][BYTE_W-1:0] sig_tab,
  output chan_t                        even_q,
  output chan_t                        odd_q,
  output logic                         si_a_q,
  output logic                         si_b_q
);
  // one register per multiframe position
  for (genvar f = 0; f < MF_LEN; f++) begin : g_pos
    chan_t q;
    always_ff @(posedge clk) begin
      if (rst) q <= '1;
      else if (sig_vld && sig_frm == FW'(f)) q <= sig_byte;
    end
    assign sig_tab[f] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      even_q <= '1;
      odd_q  <= '1;
      si_a_q <= 1'b1;
      si_b_q <= 1'b1;
    end else if (aln_vld) begin
      if (aln_frm[0]) odd_q <= aln_byte;
      else            even_q <= aln_byte;
      if (aln_frm == FW'(SI_A)) si_a_q <= aln_byte[BYTE_W-1];
      if (aln_frm == FW'(SI_B)) si_b_q <= aln_byte[BYTE_W-1];
    end
  end
endmodule

// File: rtl/csa_crc_cnt.sv
module csa_crc_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         err_i,
  input  logic         maint_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)                   cnt_o <= '0;
    else if (maint_i && tick_i) cnt_o <= W'(err_i);
    else if (err_i)            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/csa_err_tgl.sv
module csa_err_tgl #(
  parameter int unsigned DIV = 16,
  parameter int unsigned CW  = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_i,
  output logic flag_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      flag_o <= 1'b0;
    end else if (ev_i) begin
      if (cnt == CW'(DIV - 1)) begin
        cnt    <= '0;
        flag_o <= ~flag_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csa_serializer.sv
module csa_serializer #(
  parameter int unsigned N_CH = 32,
  parameter int unsigned W    = 8,
  parameter int unsigned CHW  = $clog2(N_CH),
  parameter int unsigned BW   = $clog2(W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_i,
  input  logic [N_CH-1:0][W-1:0]  live_i,
  input  logic [CHW-1:0]          rd_ch_i,
  input  logic [BW-1:0]           rd_bit_i,
  output logic                    so_o
);
  logic [W-1:0] shadow [N_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int unsigned c = 0; c < N_CH; c++) shadow[c] <= '1;
      so_o <= 1'b1;
    end else if (load_i) begin
      for (int unsigned c = 0; c < N_CH; c++) shadow[c] <= live_i[c];
      so_o <= live_i[0][W-1];
    end else begin
      so_o <= shadow[rd_ch_i][rd_bit_i];
    end
  end
endmodule

// File: rtl/ctl_stream_asm.sv
module ctl_stream_asm
  import ctl_stream_pkg::*;
#(
  parameter int unsigned N_CH    = 32,
  parameter int unsigned MF_LEN  = 16,
  parameter int unsigned ERR_DIV = 16,
  parameter int unsigned SI_A    = 13,
  parameter int unsigned SI_B    = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fp_i,
  input  logic                      sig_vld_i,
  input  logic [$clog2(MF_LEN)-1:0] sig_frm_i,
  input  logic [BYTE_W-1:0]         sig_byte_i,
  input  logic                      aln_vld_i,
  input  logic [$clog2(MF_LEN)-1:0] aln_frm_i,
  input  logic [BYTE_W-1:0]         aln_byte_i,
  input  logic [BYTE_W-2:0]         stat_i,
  input  logic                      fae_i,
  input  logic [BYTE_W:0]           phase_i,
  input  logic                      crc_sync_i,
  input  logic                      crc_rfr_i,
  input  logic                      crc_err_i,
  input  logic                      maint_i,
  input  logic                      sec_tick_i,
  output logic                      ctl_so_o
);
  localparam int unsigned W     = BYTE_W;
  localparam int unsigned FW    = $clog2(MF_LEN);
  localparam int unsigned BW    = $clog2(W);
  localparam int unsigned CHW   = $clog2(N_CH);
  localparam int unsigned POS_W = $clog2(N_CH * W);

  logic [MF_LEN-1:0][W-1:0] sig_tab;
  chan_t                    even_q, odd_q;
  logic                     si_a, si_b;
  logic [W-1:0]             crc_cnt;
  logic                     err_flag;
  logic [POS_W-1:0]         bit_pos;
  logic [N_CH-1:0][W-1:0]   live;

  csa_capture #(.MF_LEN(MF_LEN), .SI_A(SI_A), .SI_B(SI_B), .FW(FW)) u_cap (
    .clk(clk), .rst(rst),
    .sig_vld(sig_vld_i), .sig_frm(sig_frm_i), .sig_byte(sig_byte_i),
    .aln_vld(aln_vld_i), .aln_frm(aln_frm_i), .aln_byte(aln_byte_i),
    .sig_tab(sig_tab), .even_q(even_q), .odd_q(odd_q),
    .si_a_q(si_a), .si_b_q(si_b)
  );

  csa_crc_cnt #(.W(W)) u_crc (
    .clk(clk), .rst(rst), .err_i(crc_err_i), .maint_i(maint_i),
    .tick_i(sec_tick_i), .cnt_o(crc_cnt)
  );

  csa_err_tgl #(.DIV(ERR_DIV)) u_err (
    .clk(clk), .rst(rst), .ev_i(fae_i), .flag_o(err_flag)
  );

  // bit sequencer: index of the next bit to present
  always_ff @(posedge clk) begin
    if (rst)       bit_pos <= '0;
    else if (fp_i) bit_pos <= POS_W'(1);
    else           bit_pos <= bit_pos + 1'b1;
  end

  // channel map; unlisted channels stay all ones
  always_comb begin
    live = '1;
    for (int unsigned f = 0; f < MF_LEN; f++) live[f] = sig_tab[f];
    live[CH_FAS]  = even_q;
    live[CH_NFAS] = odd_q;
    live[CH_MSW]  = {stat_i, err_flag};
    live[CH_PHS]  = phase_i[W-1:0];
    live[CH_CRC]  = crc_cnt;
    live[CH_MSW2] = {si_a, si_b, crc_rfr_i, crc_sync_i, 3'b111, phase_i[W]};
  end

  csa_serializer #(.N_CH(N_CH), .W(W), .CHW(CHW), .BW(BW)) u_ser (
    .clk(clk), .rst(rst), .load_i(fp_i), .live_i(live),
    .rd_ch_i(bit_pos[POS_W-1:BW]), .rd_bit_i(~bit_pos[BW-1:0]),
    .so_o(ctl_so_o)
  );
endmodule

// File: rtl/ctl_stream_asm_chk.sv
module ctl_stream_asm_chk #(
  parameter int unsigned POS_W    = 8,
  parameter int unsigned SPARE_LO = 176
) (
  input logic             clk,
  input logic             rst,
  input logic             fp_i,
  input logic             crc_err_i,
  input logic             maint_i,
  input logic             sec_tick_i,
  input logic             fae_i,
  input logic [7:0]       crc_cnt,
  input logic             err_flag,
  input logic [POS_W-1:0] bit_pos,
  input logic             ctl_so_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> ctl_so_o);

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    fp_i |=> bit_pos == POS_W'(1));

  // R8
  crc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_err_i && !(maint_i && sec_tick_i)) |=> crc_cnt == 8'($past(crc_cnt) + 8'd1));

  // R9
  crc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (maint_i && sec_tick_i && !crc_err_i) |=> crc_cnt == 8'd0);

  // R9
  crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!crc_err_i && !(maint_i && sec_tick_i)) |=> $stable(crc_cnt));

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fae_i |=> $stable(err_flag));

  // R10
  spare_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (!fp_i && int'(bit_pos) >= SPARE_LO) |=> ctl_so_o);
endmodule

bind ctl_stream_asm ctl_stream_asm_chk u_chk (
  .clk(clk), .rst(rst), .fp_i(fp_i), .crc_err_i(crc_err_i),
  .maint_i(maint_i), .sec_tick_i(sec_tick_i), .fae_i(fae_i),
  .crc_cnt(crc_cnt), .err_flag(err_flag), .bit_pos(bit_pos),
  .ctl_so_o(ctl_so_o)
);

// File: tb/ctl_stream_asm_test.sv
module ctl_stream_asm_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, fp_i = 1'b0;
  logic       sig_vld_i = 1'b0, aln_vld_i = 1'b0;
  logic [3:0] sig_frm_i = '0, aln_frm_i = '0;
  logic [7:0] sig_byte_i = '0, aln_byte_i = '0;
  logic [6:0] stat_i = '0;
  logic [8:0] phase_i = '0;
  logic       fae_i = 1'b0, crc_sync_i = 1'b0, crc_rfr_i = 1'b0;
  logic       crc_err_i = 1'b0, maint_i = 1'b0, sec_tick_i = 1'b0;
  logic       ctl_so_o;

  ctl_stream_asm uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] got [32];
  logic [7:0] m_sig [16];
  logic [7:0] m_even, m_odd;
  logic       m_si13, m_si15;
  int         m_crc, m_fae;

  function automatic logic [7:0] exp_ch(int c);
    if (c < 16)  return m_sig[c];
    if (c == 16) return m_even;
    if (c == 17) return m_odd;
    if (c == 18) return {stat_i, 1'((m_fae / 16) % 2)};
    if (c == 19) return phase_i[7:0];
    if (c == 20) return 8'(m_crc);
    if (c == 21) return {m_si13, m_si15, crc_rfr_i, crc_sync_i, 3'b111, phase_i[8]};
    return 8'hFF;
  endfunction

  function automatic string req_of(int c);
    if (c < 16) return "R3";
    if (c < 18) return "R4";
    if (c == 18) return "R5";
    if (c == 19) return "R6";
    if (c == 20) return "R8";
    if (c == 21) return "R7";
    return "R10";
  endfunction

  task automatic grab(input bit with_fp);
    if (with_fp) begin
      @(negedge clk) fp_i = 1'b1;
    end
    for (int k = 0; k < 256; k++) begin
      @(negedge clk) fp_i = 1'b0;
      got[k / 8][7 - (k % 8)] = ctl_so_o;
    end
  endtask

  task automatic check_frame(input string what);
    for (int c = 0; c < 32; c++) begin
      n_chk++;
      if (got[c] !== exp_ch(c)) begin
        n_bad++;
        $display("FAIL %s %s ch%0d got %h exp %h", req_of(c), what, c, got[c], exp_ch(c));
      end
    end
  endtask

  task automatic put_sig(input int f, input logic [7:0] b);
    @(negedge clk) begin sig_vld_i = 1'b1; sig_frm_i = 4'(f); sig_byte_i = b; end
    @(negedge clk) sig_vld_i = 1'b0;
  endtask

  task automatic put_aln(input int f, input logic [7:0] b);
    @(negedge clk) begin aln_vld_i = 1'b1; aln_frm_i = 4'(f); aln_byte_i = b; end
    @(negedge clk) aln_vld_i = 1'b0;
    if (f % 2 == 0) m_even = b; else m_odd = b;
    if (f == 13) m_si13 = b[7];
    if (f == 15) m_si15 = b[7];
  endtask

  task automatic pulse_crc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) crc_err_i = 1'b1;
    end
    @(negedge clk) crc_err_i = 1'b0;
    m_crc = (m_crc + n) % 256;
  endtask

  task automatic pulse_fae(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fae_i = 1'b1;
    end
    @(negedge clk) fae_i = 1'b0;
    m_fae += n;
  endtask

  task automatic tick(input bit m, input bit e);
    @(negedge clk) begin maint_i = m; sec_tick_i = 1'b1; crc_err_i = e; end
    @(negedge clk) begin sec_tick_i = 1'b0; crc_err_i = 1'b0; maint_i = 1'b0; end
    if (m) m_crc = e ? 1 : 0;
    else if (e) m_crc = (m_crc + 1) % 256;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit ones;
    logic [7:0] old;
    for (int f = 0; f < 16; f++) m_sig[f] = 8'hFF;
    m_even = 8'hFF; m_odd = 8'hFF; m_si13 = 1'b1; m_si15 = 1'b1;
    m_crc = 0; m_fae = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: idle ones before the first frame pulse
    ones = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (ctl_so_o !== 1'b1) ones = 1'b0;
    end
    n_chk++;
    if (!ones) begin n_bad++; $display("FAIL R1 idle output got 0 exp 1"); end
    grab(1'b1);
    check_frame("R1 reset frame");

    // R3 R4 R6 R7: pattern sweep over every position
    for (int p = 0; p < 4; p++) begin
      stat_i     = 7'((p * 43 + 21) % 128);
      crc_rfr_i  = p[0];
      crc_sync_i = p[1];
      case (p)
        0: phase_i = 9'h000;
        1: phase_i = 9'h1FF;
        2: phase_i = 9'h155;
        default: phase_i = 9'h0AA;
      endcase
      for (int f = 0; f < 16; f++) begin
        m_sig[f] = 8'((f * 29 + p * 71 + 3) % 256);
        put_sig(f, m_sig[f]);
        put_aln(f, 8'((f * 53 + p * 17 + 155) % 256));
      end
      grab(1'b1);
      check_frame("pattern");
      if (p == 0) begin
        grab(1'b0);
        check_frame("R2 repeat without pulse");
      end
    end

    // R11: a capture during a frame waits for the next pulse
    old = m_sig[10];
    fork
      grab(1'b1);
      begin
        repeat (40) @(negedge clk);
        put_sig(10, ~old);
      end
    join
    check_frame("R11 old value held");
    m_sig[10] = ~old;
    grab(1'b1);
    check_frame("R11 new value after pulse");

    // R8: counting and the exact wrap
    pulse_crc(5);
    grab(1'b1); check_frame("R8 five errors");
    pulse_crc(300);
    grab(1'b1); check_frame("R8 300 more");
    pulse_crc(255 - m_crc);
    grab(1'b1); check_frame("R8 at 255");
    pulse_crc(1);
    grab(1'b1); check_frame("R8 wrap to 0");

    // R9: per-second clear
    pulse_crc(7);
    tick(1'b0, 1'b0);
    grab(1'b1); check_frame("R9 tick ignored without maint");
    tick(1'b1, 1'b0);
    grab(1'b1); check_frame("R9 cleared");
    pulse_crc(3);
    tick(1'b1, 1'b1);
    grab(1'b1); check_frame("R9 clear with error");

    // R5: error bit toggle point
    pulse_fae(15);
    grab(1'b1); check_frame("R5 15 events");
    pulse_fae(1);
    grab(1'b1); check_frame("R5 16 events");
    pulse_fae(16);
    grab(1'b1); check_frame("R5 32 events");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule